// File: doc/BRIEF.md
# Card Clock Generator with Commit Handshake

This block produces the clock for a memory-card bus from a faster module clock. Software programs a pending configuration: a 16-bit divide ratio, a clock-enable bit and a low-power bit. Writing that configuration does not change the card clock. The new settings reach the clock logic only when software issues a clock-update command, which is a start request with the "update clock only" qualifier set. While the request is outstanding the start flag reads 1. The block applies the pending settings at a safe point, where the card clock is low, and then clears the flag to show that the new settings are in effect.

A frequency change takes three commits. Software first turns the enable off and commits. It then writes a divide ratio of zero and commits. Finally it writes the new ratio with the enable set and commits again. The clock is therefore stopped while the ratio changes. An optional wait qualifier holds the commit back while the command path reports a busy transfer. Low-power mode gates the clock whenever no transfer is active. The card clock is generated as a registered signal in the module-clock domain. A one-cycle qualifier marks each card-clock rising edge.

Top module: `card_clk_ctrl`

## Requirements
- R1: After reset, card_clk, card_clk_en and start_flag are 0, and the committed configuration has the clock disabled.
- R2: A write to the control word (bits 15:0 divide ratio, bit 16 clock enable, bit 17 low-power enable) only updates the pending configuration. The card clock output does not change until a commit.
- R3: A command write with both cmd_start and cmd_upd_only set makes start_flag read 1 from the next cycle. start_flag clears in the cycle after the pending configuration is committed.
- R4: A command write with cmd_start set and cmd_upd_only clear is ignored: start_flag stays 0 and the card clock keeps its committed settings.
- R5: With a committed divide ratio N of 1 or more and the clock running, card_clk is high for N cycles and low for N cycles. A ratio of 0 gives the fastest rate, which is 1 cycle high and 1 cycle low.
- R6: A commit happens only in a cycle where card_clk is low. The commit restarts the phase, so the next low phase and every high phase last a full half period at the ratio in force.
- R7: If cmd_wait_prev was set with the request, the commit is held while xfer_busy is 1. Without it, xfer_busy has no effect.
- R8: With low-power mode committed, card_clk is held low while xfer_active is 0 and runs while xfer_active is 1.
- R9: card_clk_en is 1 for exactly the cycle in which card_clk is first high after being low, and 0 otherwise.
- R10: With the enable committed as 0, card_clk is held low. After the off, zero-ratio, new-ratio commit sequence, the clock runs at the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_we | input | 1 | Write strobe for the control word |
| ctl_wdata | input | 18 | Control word: ratio [15:0], enable [16], low-power [17] |
| cmd_we | input | 1 | Write strobe for the command word |
| cmd_start | input | 1 | Command start request |
| cmd_upd_only | input | 1 | Request only commits the clock settings |
| cmd_wait_prev | input | 1 | Hold commit while the transfer path is busy |
| xfer_busy | input | 1 | Busy indication from the command/data path |
| xfer_active | input | 1 | A command or data transfer is in progress |
| card_clk | output | 1 | Card clock, registered |
| card_clk_en | output | 1 | One-cycle marker of a card-clock rising edge |
| start_flag | output | 1 | Readable start flag; 1 while a commit is pending |

## Verification
The bench checks that pending writes leave the running clock untouched. A design that applied the ratio early would show a changed period before the commit. It holds a commit under busy with the wait qualifier set. A design that ignored the qualifier would clear the start flag while busy is still high. It also issues commits during high phases. A design that committed at any point would clip a high pulse short or restart the clock mid-phase, and the behavioural model, which is compared every cycle, would see a phase mismatch. Other cases covered are ratio 0 versus ratio 1, low-power gating as the transfer activity toggles, a start without the update qualifier, and the three-step frequency change.

// File: rtl/card_clk_pkg.sv
package card_clk_pkg;
  localparam int DIV_W  = 16;
  localparam int EN_POS = 16;
  localparam int LP_POS = 17;
  localparam int CTL_W  = 18;

  typedef struct packed {
    logic             lp;
    logic             en;
    logic [DIV_W-1:0] div;
  } clk_cfg_t;
endpackage

// File: rtl/ccc_commit_ctrl.sv
module ccc_commit_ctrl
  import card_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             cmd_we,
  input  logic             cmd_start,
  input  logic             cmd_upd_only,
  input  logic             cmd_wait_prev,
  input  logic             xfer_busy,
  input  logic             clk_low,
  output logic             commit,
  output clk_cfg_t         act_cfg,
  output logic             start_flag
);
  clk_cfg_t pend_cfg;
  logic     wait_q;

  assign commit = start_flag && !(wait_q && xfer_busy) && clk_low;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_cfg <= '0;
    end else if (ctl_we) begin
      pend_cfg.div <= ctl_wdata[DIV_W-1:0];
      pend_cfg.en  <= ctl_wdata[EN_POS];
      pend_cfg.lp  <= ctl_wdata[LP_POS];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      start_flag <= 1'b0;
      wait_q     <= 1'b0;
      act_cfg    <= '0;
    end else if (commit) begin
      start_flag <= 1'b0;
      act_cfg    <= pend_cfg;
    end else if (!start_flag && cmd_we && cmd_start && cmd_upd_only) begin
      start_flag <= 1'b1;
      wait_q     <= cmd_wait_prev;
    end
  end

  // R7: a held request survives while busy blocks it
  assert_hold_busy_R7: assert property (@(posedge clk) disable iff (rst)
    (start_flag && wait_q && xfer_busy) |=> start_flag);

  // R4: a start without the update qualifier never raises the flag
  assert_plain_start_ignored_R4: assert property (@(posedge clk) disable iff (rst)
    (!start_flag && cmd_we && !cmd_upd_only) |=> !start_flag);

  // R3: the flag only drops through a commit
  assert_flag_drop_commit_R3: assert property (@(posedge clk) disable iff (rst)
    (start_flag && !commit) |=> start_flag);
endmodule

// File: rtl/ccc_divider.sv
module ccc_divider
  import card_clk_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  clk_cfg_t act_cfg,
  input  logic     commit,
  input  logic     xfer_active,
  output logic     card_clk,
  output logic     card_clk_en
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] half_m1;
  logic             run;

  assign half_m1 = (act_cfg.div == '0) ? '0 : act_cfg.div - 1'b1;
  assign run     = act_cfg.en && !(act_cfg.lp && !xfer_active);

  always_ff @(posedge clk) begin
    if (rst || commit || !run) begin
      card_clk    <= 1'b0;
      card_clk_en <= 1'b0;
      cnt         <= '0;
    end else if (cnt == half_m1) begin
      card_clk    <= ~card_clk;
      card_clk_en <= ~card_clk;
      cnt         <= '0;
    end else begin
      card_clk_en <= 1'b0;
      cnt         <= cnt + 1'b1;
    end
  end

  // R9: the qualifier marks only a fresh rising edge
  assert_en_on_rise_R9: assert property (@(posedge clk) disable iff (rst)
    card_clk_en |-> (card_clk && !$past(card_clk)));

  // R8: low-power gating forces the clock low
  assert_lp_gate_R8: assert property (@(posedge clk) disable iff (rst)
    (act_cfg.lp && !xfer_active) |=> !card_clk);

  // R10: a disabled clock stays low
  assert_off_low_R10: assert property (@(posedge clk) disable iff (rst)
    !act_cfg.en |=> !card_clk);
endmodule

// File: rtl/card_clk_ctrl.sv
module card_clk_ctrl
  import card_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             cmd_we,
  input  logic             cmd_start,
  input  logic             cmd_upd_only,
  input  logic             cmd_wait_prev,
  input  logic             xfer_busy,
  input  logic             xfer_active,
  output logic             card_clk,
  output logic             card_clk_en,
  output logic             start_flag
);
  clk_cfg_t act_cfg;
  logic     commit;

  ccc_commit_ctrl u_commit (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cmd_we(cmd_we), .cmd_start(cmd_start), .cmd_upd_only(cmd_upd_only),
    .cmd_wait_prev(cmd_wait_prev), .xfer_busy(xfer_busy),
    .clk_low(!card_clk), .commit(commit), .act_cfg(act_cfg),
    .start_flag(start_flag)
  );

  ccc_divider u_div (
    .clk(clk), .rst(rst), .act_cfg(act_cfg), .commit(commit),
    .xfer_active(xfer_active), .card_clk(card_clk), .card_clk_en(card_clk_en)
  );

  // R6: the start flag clears only after a low card-clock cycle
  assert_commit_low_R6: assert property (@(posedge clk) disable iff (rst)
    $fell(start_flag) |-> !$past(card_clk));
endmodule

// File: tb/card_clk_ctrl_bench.sv
module card_clk_ctrl_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ctl_we = 1'b0;
  logic [17:0] ctl_wdata = '0;
  logic cmd_we = 1'b0, cmd_start = 1'b0, cmd_upd_only = 1'b0, cmd_wait_prev = 1'b0;
  logic xfer_busy = 1'b0, xfer_active = 1'b0;
  logic card_clk, card_clk_en, start_flag;

  int total = 0;
  int bad = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  card_clk_ctrl u_card_clk_ctrl (
    .clk(clk), .rst(rst), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .cmd_we(cmd_we), .cmd_start(cmd_start), .cmd_upd_only(cmd_upd_only),
    .cmd_wait_prev(cmd_wait_prev), .xfer_busy(xfer_busy),
    .xfer_active(xfer_active), .card_clk(card_clk),
    .card_clk_en(card_clk_en), .start_flag(start_flag)
  );

  // behavioural reference
  int  m_pdiv, m_adiv, m_cnt;
  bit  m_pen, m_plp, m_aen, m_alp, m_start, m_wait, m_ck, m_en;

  always @(posedge clk) begin
    bit cm, run;
    int half;
    if (rst) begin
      m_pdiv = 0; m_adiv = 0; m_pen = 0; m_plp = 0; m_aen = 0; m_alp = 0;
      m_start = 0; m_wait = 0; m_ck = 0; m_en = 0; m_cnt = 0;
    end else begin
      cm   = m_start && !(m_wait && xfer_busy) && !m_ck;
      run  = m_aen && !(m_alp && !xfer_active);
      half = (m_adiv == 0) ? 1 : m_adiv;
      if (cm || !run) begin
        m_ck = 0; m_en = 0; m_cnt = 0;
      end else if (m_cnt + 1 >= half) begin
        m_en = !m_ck; m_ck = !m_ck; m_cnt = 0;
      end else begin
        m_en = 0; m_cnt++;
      end
      if (cm) begin
        m_start = 0; m_adiv = m_pdiv; m_aen = m_pen; m_alp = m_plp;
      end else if (!m_start && cmd_we && cmd_start && cmd_upd_only) begin
        m_start = 1; m_wait = cmd_wait_prev;
      end
      if (ctl_we) begin
        m_pdiv = int'(ctl_wdata[15:0]); m_pen = ctl_wdata[16]; m_plp = ctl_wdata[17];
      end
    end
  end

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (!rst) begin
      check("R5", "card_clk vs model", int'(card_clk), int'(m_ck));
      check("R9", "card_clk_en vs model", int'(card_clk_en), int'(m_en));
      check("R3", "start_flag vs model", int'(start_flag), int'(m_start));
    end
    if (cycles > 100000) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr_ctl(input int div, input bit en, input bit lp);
    @(negedge clk);
    ctl_we = 1; ctl_wdata = {lp, en, 16'(div)};
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic wr_cmd(input bit st, input bit upd, input bit wt);
    @(negedge clk);
    cmd_we = 1; cmd_start = st; cmd_upd_only = upd; cmd_wait_prev = wt;
    @(negedge clk);
    cmd_we = 0; cmd_start = 0; cmd_upd_only = 0; cmd_wait_prev = 0;
  endtask

  task automatic wait_clear();
    for (int i = 0; i < 300 && start_flag; i++) @(negedge clk);
    check("R3", "start_flag cleared", int'(start_flag), 0);
  endtask

  task automatic measure(output int hi, output int lo);
    logic prev;
    hi = 0; lo = 0; prev = card_clk;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (card_clk && !prev) break;
      prev = card_clk;
    end
    if (!card_clk) return;
    hi = 1;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (!card_clk) break; hi++; end
    lo = 1;
    for (int i = 0; i < 400; i++) begin @(negedge clk); if (card_clk) break; lo++; end
  endtask

  task automatic stays_low(input string req, input int n);
    int highs = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (card_clk) highs++; end
    check(req, "high cycles while stopped", highs, 0);
  endtask

  initial begin
    int hi, lo;
    repeat (3) @(negedge clk);
    check("R1", "card_clk after reset", int'(card_clk), 0);
    check("R1", "card_clk_en after reset", int'(card_clk_en), 0);
    check("R1", "start_flag after reset", int'(start_flag), 0);
    rst = 0;

    wr_ctl(3, 1, 0);
    stays_low("R2", 20);

    wr_cmd(1, 1, 0);
    check("R3", "start_flag after request", int'(start_flag), 1);
    wait_clear();
    measure(hi, lo);
    check("R5", "high len div3", hi, 3);
    check("R5", "low len div3", lo, 3);

    wr_ctl(7, 1, 0);
    measure(hi, lo);
    check("R2", "pending div not applied", hi, 3);

    wr_cmd(1, 0, 0);
    check("R4", "plain start ignored", int'(start_flag), 0);
    measure(hi, lo);
    check("R4", "period unchanged", hi, 3);

    wr_ctl(1, 1, 0);
    xfer_busy = 1;
    wr_cmd(1, 1, 1);
    repeat (20) @(negedge clk);
    check("R7", "flag held while busy", int'(start_flag), 1);
    measure(hi, lo);
    check("R7", "old ratio while held", hi, 3);
    xfer_busy = 0;
    wait_clear();
    measure(hi, lo);
    check("R5", "high len div1", hi, 1);

    wr_ctl(0, 1, 0);
    xfer_busy = 1;
    wr_cmd(1, 1, 0);
    wait_clear();
    check("R7", "busy ignored without wait", int'(start_flag), 0);
    xfer_busy = 0;
    measure(hi, lo);
    check("R5", "high len div0", hi, 1);
    check("R5", "low len div0", lo, 1);

    wr_ctl(4, 1, 0);
    wr_cmd(1, 1, 0);
    wait_clear();
    for (int k = 0; k < 3; k++) begin
      wr_ctl(4 + k, 1, 0);
      wr_cmd(1, 1, 0);
      wait_clear();
      measure(hi, lo);
      check("R6", "full high after commit", hi, 4 + k);
    end

    wr_ctl(2, 1, 1);
    xfer_active = 0;
    wr_cmd(1, 1, 0);
    wait_clear();
    stays_low("R8", 20);
    xfer_active = 1;
    measure(hi, lo);
    check("R8", "runs when active", hi, 2);
    xfer_active = 0;
    stays_low("R8", 10);

    wr_ctl(2, 0, 0);
    wr_cmd(1, 1, 0);
    wait_clear();
    stays_low("R10", 15);
    wr_ctl(0, 0, 0);
    wr_cmd(1, 1, 0);
    wait_clear();
    stays_low("R10", 10);
    wr_ctl(5, 1, 0);
    wr_cmd(1, 1, 0);
    wait_clear();
    measure(hi, lo);
    check("R10", "new ratio high", hi, 5);
    check("R10", "new ratio low", lo, 5);

    repeat (10) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule